// File: doc/BRIEF.md
# Accumulator-Fed Eight-Operation ALU

A narrow arithmetic and logic unit for a very small processor. It takes a 3-bit operation code and an operand A from memory. The second operand is not chosen from a register file. It is always the result of the previous executed operation, held in an internal last-result register. Each operation produces a result and a carry flag in the same cycle as its inputs. When the execute strobe is high at a clock edge, the result is loaded into the last-result register, where it becomes operand B for the next operation.

The eight operations are a plus B, A minus one, bitwise XNOR, AND, OR, A OR (NOT B), pass B and pass A. Two code points that a plain 16-function logic table would spend on !A|B and on the constant one are given to addition and decrement instead, so that every code does useful work. Because B is always the previous result, a program builds inversions from short sequences. For example, a NAND is an AND followed by A OR (NOT B) with A = 0.

Top module: `acc_alu8`

## Requirements
- R1: With code 000 (add), result equals (A + B) mod 2^W and carry equals bit W of the full sum.
- R2: With code 100 (decrement), result equals (A - 1) mod 2^W, so A = 0 wraps to all ones. Carry is 0 exactly when A is 0 (a borrow) and 1 otherwise.
- R3: The bitwise codes give these results, each with carry forced to 0: 001 = A XNOR B, 011 = A AND B, 101 = A OR (NOT B), 110 = A OR B.
- R4: Code 010 (last) outputs B unchanged and code 111 (move) outputs A unchanged, both with carry 0.
- R5: A synchronous reset clears the last-result register to zero. After reset, code 010 reads back 0.
- R6: The last-result register takes the current result at a rising clock edge when the execute strobe is 1. When the strobe is 0 the register keeps its value.
- R7: Result and carry are combinational in the opcode, in A and in the stored B, with no added latency.
- R8: Move X with the strobe, then add Y, gives (X + Y) mod 2^W. Move X, AND with Y, then A OR (NOT B) with A = 0 leaves NOT(X AND Y) in the last-result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code (encodings in R1 to R4) |
| a_i | input | W | Operand A from memory |
| exec_i | input | 1 | Execute strobe: load the result into the last-result register |
| result_o | output | W | Operation result |
| carry_o | output | 1 | Carry out of add, no-borrow flag of decrement, 0 otherwise |

## Verification
The bench uses the default data width of four bits. At that width every pair of A and stored B values, 256 in all, can be checked for each of the eight codes, with B loaded through a move before each sweep. This covers the carry out of the top bit, the wrap of decrement from zero, and the all-ones and all-zeros patterns of every bitwise function. Extra sequences check that B holds while the strobe is low, that a mid-run reset clears B, and that a move-add chain and the three-step NAND give the expected values.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

    // Operation codes; the three bits mirror the low select bits of a
    // 16-function logic table whose top select and mode bits are held high.
    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_XNOR = 3'b001,
        OP_LAST = 3'b010,
        OP_AND  = 3'b011,
        OP_DEC  = 3'b100,
        OP_ORN  = 3'b101,
        OP_OR   = 3'b110,
        OP_MOVE = 3'b111
    } op_e;

    // Control word produced by the decoder.
    // truth is indexed by {a_bit, b_bit}.
    typedef struct packed {
        logic       arith;     // 1: adder path, 0: bitwise path
        logic       minus_one; // adder second input forced to all ones
        logic [3:0] truth;     // per-bit function table for bitwise path
    } ctl_t;

    localparam logic [3:0] TT_XNOR = 4'b1001;
    localparam logic [3:0] TT_B    = 4'b1010;
    localparam logic [3:0] TT_AND  = 4'b1000;
    localparam logic [3:0] TT_ORN  = 4'b1101;
    localparam logic [3:0] TT_OR   = 4'b1110;
    localparam logic [3:0] TT_A    = 4'b1100;

endpackage

// File: rtl/acc_alu8_decode.sv
module acc_alu8_decode
    import acc_alu8_pkg::*;
(
    input  logic [2:0] op_i,
    output ctl_t       ctl_o
);

    op_e op;

    always_comb begin
        op    = op_e'(op_i);
        ctl_o = '0;
        case (op)
            OP_ADD: begin
                ctl_o.arith     = 1'b1;
                ctl_o.minus_one = 1'b0;
            end
            OP_DEC: begin
                ctl_o.arith     = 1'b1;
                ctl_o.minus_one = 1'b1;
            end
            OP_XNOR: ctl_o.truth = TT_XNOR;
            OP_LAST: ctl_o.truth = TT_B;
            OP_AND:  ctl_o.truth = TT_AND;
            OP_ORN:  ctl_o.truth = TT_ORN;
            OP_OR:   ctl_o.truth = TT_OR;
            OP_MOVE: ctl_o.truth = TT_A;
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu8_core.sv
module acc_alu8_core
    import acc_alu8_pkg::*;
#(
    parameter int W = 4
) (
    input  ctl_t         ctl_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         carry_o
);

    logic [W:0]   chain;
    logic [W-1:0] sum_bits;
    logic [W-1:0] logic_bits;

    assign chain[0] = 1'b0;

    // One slice per bit: full adder plus a table-driven bitwise function.
    for (genvar i = 0; i < W; i++) begin : g_slice
        logic addend;
        always_comb begin
            addend        = ctl_i.minus_one ? 1'b1 : b_i[i];
            sum_bits[i]   = a_i[i] ^ addend ^ chain[i];
            chain[i+1]    = (a_i[i] & addend) | (chain[i] & (a_i[i] ^ addend));
            logic_bits[i] = ctl_i.truth[{a_i[i], b_i[i]}];
        end
    end

    always_comb begin
        res_o   = ctl_i.arith ? sum_bits : logic_bits;
        carry_o = ctl_i.arith & chain[W];
    end

endmodule

// File: rtl/acc_alu8_lastreg.sv
module acc_alu8_lastreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] last_o
);

    typedef struct packed {
        logic [W-1:0] last;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.last = val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = st_q.last;

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu8_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic         exec_i,
    output logic [W-1:0] result_o,
    output logic         carry_o
);

    ctl_t         ctl;
    logic [W-1:0] last_q;
    logic [W-1:0] res;
    logic         cy;

    acc_alu8_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    acc_alu8_core #(.W(W)) u_core (
        .ctl_i   (ctl),
        .a_i     (a_i),
        .b_i     (last_q),
        .res_o   (res),
        .carry_o (cy)
    );

    acc_alu8_lastreg #(.W(W)) u_last (
        .clk    (clk),
        .rst    (rst),
        .load_i (exec_i),
        .val_i  (res),
        .last_o (last_q)
    );

    assign result_o = res;
    assign carry_o  = cy;

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op,
    input logic [W-1:0] a,
    input logic         exec_en,
    input logic [W-1:0] res,
    input logic         carry,
    input logic [W-1:0] last
);

    // R6: strobe low keeps the stored operand
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(last));

    // R6: strobe high captures the result
    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> last == $past(res));

    // R3: bitwise codes never raise carry
    assert_logic_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b001 || op == 3'b011 || op == 3'b101 || op == 3'b110) |-> !carry);

    // R4: move passes A
    assert_move_R4: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b111) |-> (res == a && !carry));

    // R4: last passes stored B
    assert_last_R4: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b010) |-> (res == last && !carry));

    // R2: decrement of zero wraps with borrow
    assert_dec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b100 && a == '0) |-> (res == '1 && !carry));

    // R5: reset clears the stored operand
    assert_reset_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> last == '0);

endmodule

bind acc_alu8 acc_alu8_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op_i),
    .a       (a_i),
    .exec_en (exec_i),
    .res     (result_o),
    .carry   (carry_o),
    .last    (last_q)
);

// File: tb/acc_alu8_tb_top.sv
`timescale 1ns/1ps
module acc_alu8_tb_top;

    localparam int W = 4;
    localparam int N = 1 << W;

    typedef struct {
        logic [W-1:0] res;
        logic         cy;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op  = 3'b000;
    logic [W-1:0] a   = '0;
    logic         ex  = 1'b0;
    logic [W-1:0] result;
    logic         carry;

    item_t        sb_q[$];
    logic [W-1:0] b_model = '0;
    int           checks  = 0;
    int           errors  = 0;
    bit           done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    acc_alu8 #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .a_i      (a),
        .exec_i   (ex),
        .result_o (result),
        .carry_o  (carry)
    );

    // Reference behaviour written from the requirements.
    function automatic void model(input logic [2:0] o, input logic [W-1:0] av,
                                  input logic [W-1:0] bv,
                                  output logic [W-1:0] r, output logic c);
        logic [W:0] s;
        c = 1'b0;
        case (o)
            3'b000: begin s = {1'b0, av} + {1'b0, bv}; r = s[W-1:0]; c = s[W]; end // R1
            3'b100: begin r = av - 1'b1; c = (av != '0); end                        // R2
            3'b001: r = ~(av ^ bv);                                                 // R3
            3'b011: r = av & bv;
            3'b101: r = av | ~bv;
            3'b110: r = av | bv;
            3'b010: r = bv;                                                         // R4
            default: r = av;
        endcase
    endfunction

    // Driver: applies one operation and pushes the expected item.
    task automatic drive(input logic [2:0] o, input logic [W-1:0] av,
                         input logic e, input string tag);
        item_t it;
        @(negedge clk);
        op = o; a = av; ex = e;
        model(o, av, b_model, it.res, it.cy);
        it.tag = tag;
        sb_q.push_back(it);
        if (e) b_model = it.res;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ex = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        b_model = '0;
    endtask

    // Monitor: compares outputs after the driver has settled them.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (result !== it.res || carry !== it.cy) begin
                    errors++;
                    $display("FAIL %s: op=%b a=%h got res=%h cy=%b expected res=%h cy=%b",
                             it.tag, op, a, result, carry, it.res, it.cy);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R5: reset state visible through code 010
        drive(3'b010, 4'h5, 1'b0, "R5 reset clears B");

        // Exhaustive sweep: R1 R2 R3 R4 R7, B loaded by move (R6)
        for (int o = 0; o < 8; o++) begin
            for (int bv = 0; bv < N; bv++) begin
                drive(3'b111, W'(bv), 1'b1, "R6 move load");
                for (int av = 0; av < N; av++) begin
                    drive(3'(o), W'(av), 1'b0, "R1-R4 sweep R7");
                end
                drive(3'b010, '0, 1'b0, "R6 B held after sweep");
            end
        end

        // R6: strobe low leaves B
        drive(3'b111, 4'h9, 1'b1, "R6 load 9");
        drive(3'b111, 4'h3, 1'b0, "R6 no load");
        drive(3'b010, 4'h0, 1'b0, "R6 hold check");

        // R8: move-add chain
        drive(3'b111, 4'hB, 1'b1, "R8 move");
        drive(3'b000, 4'h7, 1'b1, "R8 add");
        drive(3'b010, 4'h0, 1'b0, "R8 sum stored");

        // R8: NAND sequence
        drive(3'b111, 4'h6, 1'b1, "R8 nand move");
        drive(3'b011, 4'h5, 1'b1, "R8 nand and");
        drive(3'b101, 4'h0, 1'b1, "R8 nand ornot");
        drive(3'b010, 4'h0, 1'b0, "R8 nand result");

        // R2: decrement boundary
        drive(3'b100, 4'h0, 1'b0, "R2 dec wrap");
        drive(3'b100, 4'h1, 1'b0, "R2 dec to zero");

        // R5: mid-run reset
        drive(3'b111, 4'hE, 1'b1, "R5 preload");
        do_reset();
        drive(3'b010, 4'h0, 1'b0, "R5 cleared after reset");

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule